// File: doc/BRIEF.md
# DMA Request/Acknowledge Handshake Controller

This block sits between an endpoint data buffer and an external DMA controller and runs the peripheral half of a request/acknowledge handshake. When the selected endpoint can take a word (host-to-buffer direction) or has a word to give (buffer-to-host direction), it raises a request toward the DMA controller. Once the acknowledge is active, each completed read or write strobe moves one 16-bit word. A write strobe pushes host data into the buffer. A read strobe pops the buffer word that is presented to the host.

The transfer ends in one of two ways: the programmed word count runs out, or the external end-of-transfer input becomes active. Either way the block gives a one-cycle done pulse, drops the request for that cycle, reloads the count and arms again with no register access. Request, acknowledge and end-of-transfer each have their own polarity bit.

A port-select bit picks between two strobe pairs. One is the dedicated DMA strobes, used when the DMA port is separate from the programmed-I/O port. The other is the shared programmed-I/O strobes.

Top module: `dmahs_ctrl`

## Requirements
- R1: Out of reset, with every control bit zero, the request pin is low, the done pulse is low, and neither buffer push nor buffer pop is active.
- R2: The request is active exactly one clock after the block is enabled and the buffer condition holds. In host-to-buffer mode (control bit 1 = 0) that condition is `buf_space`. In buffer-to-host mode (control bit 1 = 1) it is `buf_avail`. The request goes inactive one clock after the condition clears.
- R3: One word moves on the low-to-high edge of the selected active-low strobe, provided acknowledge was active in the cycle before that edge. In host-to-buffer mode the write strobe raises `buf_wr_valid` and `buf_wr_data` carries the host data held during the low phase. In buffer-to-host mode the read strobe raises `buf_rd_pop`, and `host_rdata` always mirrors `buf_rd_data`.
- R4: A strobe edge with acknowledge inactive moves no word and does not advance the count.
- R5: After as many words as the count register (address 1) holds, `xfer_done` pulses for one clock and the request is inactive in that clock. A count of zero behaves as a count of one.
- R6: After done, the count reloads from the register and the request returns the next clock. The next transfer again needs the full count, with no register write.
- R7: When end-of-transfer changes from inactive to active, the transfer ends at once with a done pulse and a count reload. Holding it active gives no further done pulses.
- R8: Polarity bits in the control register (address 0) select active-low operation: bit 2 for the request, bit 3 for acknowledge, bit 4 for end-of-transfer. With bit 2 set, the request pin is high when idle.
- R9: With control bit 5 set, only the dedicated DMA strobes `dma_rd_n`/`dma_wr_n` count. With it clear, only the shared strobes `pio_rd_n`/`pio_wr_n` count.
- R10: With enable (control bit 0) clear, the request stays inactive, strobes move nothing and end-of-transfer gives no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 count |
| reg_wdata | input | 16 | Register write data |
| dma_req | output | 1 | DMA request, polarity per control bit 2 |
| dma_ack | input | 1 | DMA acknowledge, polarity per control bit 3 |
| dma_eot | input | 1 | End-of-transfer, polarity per control bit 4 |
| pio_rd_n | input | 1 | Shared read strobe, active low |
| pio_wr_n | input | 1 | Shared write strobe, active low |
| dma_rd_n | input | 1 | Dedicated DMA read strobe, active low |
| dma_wr_n | input | 1 | Dedicated DMA write strobe, active low |
| host_wdata | input | 16 | Word written by the host |
| host_rdata | output | 16 | Word read by the host |
| buf_space | input | 1 | Buffer can accept a word |
| buf_wr_valid | output | 1 | Push one word into the buffer |
| buf_wr_data | output | 16 | Word pushed into the buffer |
| buf_avail | input | 1 | Buffer holds a word |
| buf_rd_data | input | 16 | Word at the buffer head |
| buf_rd_pop | output | 1 | Pop one word from the buffer |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |

## Verification
A wrong remaining-word count does not show up until the next terminal count: the done pulse then comes a word early or late. Every test therefore counts strobes up to the expected pulse and checks that it does not arrive sooner. A stale acknowledge or strobe history register shows up in the same cycle as a spurious or missing push or pop. Request logic that is wrong about polarity, enable or the buffer condition shows on `dma_req` one clock after the stimulus that should have changed it.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;
   // Control register layout, bit 0 first (en) up to bit 5 (sep)
   typedef struct packed {
      logic sep;       // dedicated DMA strobes
      logic eot_low;   // end-of-transfer active low
      logic ack_low;   // acknowledge active low
      logic req_low;   // request active low
      logic dir_in;    // 1: buffer to host
      logic en;        // enable
   } dmahs_ctrl_t;

   localparam int CTRL_W = $bits(dmahs_ctrl_t);
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_CNT  = 2'd1;

   // Strobe choice index: {sep, dir_in}
   localparam int SEL_PIO_WR = 0;
   localparam int SEL_PIO_RD = 1;
   localparam int SEL_DMA_WR = 2;
   localparam int SEL_DMA_RD = 3;
endpackage

// File: rtl/dmahs_sync.sv
module dmahs_sync #(
   parameter int W = 1,
   parameter int STAGES = 0,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);
   initial assert (STAGES >= 0 && STAGES <= 4) else $fatal(1, "dmahs_sync: STAGES out of range");

   generate
      if (STAGES == 0) begin : g_pass
         assign d_o = d_i;
      end else begin : g_ff
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d_i;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign d_o = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dmahs_regs.sv
module dmahs_regs
   import dmahs_pkg::*;
#(
   parameter int CW = 16,
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       addr,
   input  logic [REG_W-1:0] wdata,
   output dmahs_ctrl_t      ctl,
   output logic [CW-1:0]    cnt_val,
   output logic             cnt_wr
);
   initial assert (CW <= REG_W && REG_W >= CTRL_W) else $fatal(1, "dmahs_regs: width mismatch");

   assign cnt_wr = we && (addr == ADDR_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl     <= '0;
         cnt_val <= '0;
      end else begin
         if (we && addr == ADDR_CTRL) ctl <= dmahs_ctrl_t'(wdata[CTRL_W-1:0]);
         if (cnt_wr) cnt_val <= wdata[CW-1:0];
      end
   end
endmodule

// File: rtl/dmahs_xfer_cnt.sv
module dmahs_xfer_cnt #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic [CW-1:0] reload_val,
   input  logic          word,
   input  logic          eot,
   output logic          tc,
   output logic          done,
   output logic [CW-1:0] rem
);
   localparam logic [CW-1:0] ONE = CW'(1);

   initial assert (CW >= 2 && CW <= 32) else $fatal(1, "dmahs_xfer_cnt: CW out of range");

   // zero and one both end on the next word
   assign tc = eot || (word && (rem <= ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem  <= '0;
         done <= 1'b0;
      end else begin
         done <= tc;
         if (load)      rem <= load_val;
         else if (tc)   rem <= reload_val;
         else if (word) rem <= rem - ONE;
      end
   end
endmodule

// File: rtl/dmahs_ctrl.sv
module dmahs_ctrl
   import dmahs_pkg::*;
#(
   parameter int DW = 16,
   parameter int CW = 16,
   parameter int REG_W = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic             dma_req,
   input  logic             dma_ack,
   input  logic             dma_eot,
   input  logic             pio_rd_n,
   input  logic             pio_wr_n,
   input  logic             dma_rd_n,
   input  logic             dma_wr_n,
   input  logic [DW-1:0]    host_wdata,
   output logic [DW-1:0]    host_rdata,
   input  logic             buf_space,
   output logic             buf_wr_valid,
   output logic [DW-1:0]    buf_wr_data,
   input  logic             buf_avail,
   input  logic [DW-1:0]    buf_rd_data,
   output logic             buf_rd_pop,
   output logic             xfer_done
);
   localparam int NSIG = 6;
   localparam logic [NSIG-1:0] SIG_RST = {4'b1111, 2'b00};

   initial assert (DW >= 1) else $fatal(1, "dmahs_ctrl: DW must be positive");

   dmahs_ctrl_t   ctl;
   logic [CW-1:0] cnt_val;
   logic          cnt_wr;
   logic [CW-1:0] rem_w;
   logic          tc;

   dmahs_regs #(.CW(CW), .REG_W(REG_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .ctl(ctl), .cnt_val(cnt_val), .cnt_wr(cnt_wr)
   );

   // input conditioning
   logic [NSIG-1:0] raw_sig, syn_sig;
   assign raw_sig = {pio_rd_n, pio_wr_n, dma_rd_n, dma_wr_n, dma_ack, dma_eot};

   dmahs_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SIG_RST)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(raw_sig), .d_o(syn_sig)
   );

   logic s_pio_rd, s_pio_wr, s_dma_rd, s_dma_wr, s_ack, s_eot;
   assign {s_pio_rd, s_pio_wr, s_dma_rd, s_dma_wr, s_ack, s_eot} = syn_sig;

   logic en_w, dir_in_w, ack_low_w;
   assign en_w      = ctl.en;
   assign dir_in_w  = ctl.dir_in;
   assign ack_low_w = ctl.ack_low;

   // strobe choice
   logic [3:0] strb_vec;
   logic       strb_now;
   assign strb_vec[SEL_PIO_WR] = s_pio_wr;
   assign strb_vec[SEL_PIO_RD] = s_pio_rd;
   assign strb_vec[SEL_DMA_WR] = s_dma_wr;
   assign strb_vec[SEL_DMA_RD] = s_dma_rd;
   assign strb_now = strb_vec[{ctl.sep, ctl.dir_in}];

   logic ack_act, eot_act;
   assign ack_act = s_ack ^ ctl.ack_low;
   assign eot_act = s_eot ^ ctl.eot_low;

   // history of strobe, acknowledge and end-of-transfer
   logic          strb_q, ack_q, eot_q, dreq_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q <= 1'b1;
         ack_q  <= 1'b0;
         eot_q  <= 1'b0;
         data_q <= '0;
      end else begin
         strb_q <= strb_now;
         ack_q  <= ack_act;
         eot_q  <= eot_act;
         if (!strb_now) data_q <= host_wdata;
      end
   end

   logic word_evt, eot_evt, buf_cond;
   assign word_evt = ctl.en && !strb_q && strb_now && ack_q;
   assign eot_evt  = ctl.en && eot_act && !eot_q;
   assign buf_cond = ctl.dir_in ? buf_avail : buf_space;

   dmahs_xfer_cnt #(.CW(CW)) cnt_i (
      .clk(clk), .rst_n(rst_n), .load(cnt_wr), .load_val(reg_wdata[CW-1:0]),
      .reload_val(cnt_val), .word(word_evt), .eot(eot_evt),
      .tc(tc), .done(xfer_done), .rem(rem_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dreq_q <= 1'b0;
      else        dreq_q <= ctl.en && buf_cond && !tc;
   end

   assign dma_req      = dreq_q ^ ctl.req_low;
   assign buf_wr_valid = word_evt && !ctl.dir_in;
   assign buf_rd_pop   = word_evt && ctl.dir_in;
   assign buf_wr_data  = data_q;
   assign host_rdata   = buf_rd_data;
endmodule

// File: rtl/dmahs_ctrl_chk.sv
module dmahs_ctrl_chk #(
   parameter int CW = 16,
   parameter int SYNC_STAGES = 0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dreq_q,
   input logic          done,
   input logic          wr_v,
   input logic          rd_pop,
   input logic          buf_space,
   input logic          buf_avail,
   input logic          dir_in,
   input logic          en,
   input logic          ack_pin,
   input logic          ack_low,
   input logic [CW-1:0] rem,
   input logic [CW-1:0] cnt_val
);
   p_req_needs_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dreq_q |-> $past(en && (dir_in ? buf_avail : buf_space)));

   p_done_drops_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !dreq_q);

   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> rem == cnt_val);

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> !dreq_q);

   generate
      if (SYNC_STAGES == 0) begin : g_ack
         p_ack_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_v || rd_pop) |-> $past(ack_pin ^ ack_low));
      end
   endgenerate
endmodule

bind dmahs_ctrl dmahs_ctrl_chk #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) chk_i (
   .clk(clk), .rst_n(rst_n), .dreq_q(dreq_q), .done(xfer_done),
   .wr_v(buf_wr_valid), .rd_pop(buf_rd_pop), .buf_space(buf_space),
   .buf_avail(buf_avail), .dir_in(dir_in_w), .en(en_w), .ack_pin(dma_ack),
   .ack_low(ack_low_w), .rem(rem_w), .cnt_val(cnt_val)
);

// File: tb/dmahs_ctrl_tb.sv
`timescale 1ns/1ps
module dmahs_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        dma_req;
   logic        dma_ack = 1'b0, dma_eot = 1'b0;
   logic        pio_rd_n = 1'b1, pio_wr_n = 1'b1, dma_rd_n = 1'b1, dma_wr_n = 1'b1;
   logic [15:0] host_wdata = '0, host_rdata;
   logic        buf_space = 1'b0, buf_wr_valid, buf_avail = 1'b0, buf_rd_pop, xfer_done;
   logic [15:0] buf_wr_data, buf_rd_data = '0;

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   dmahs_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .dma_req(dma_req), .dma_ack(dma_ack), .dma_eot(dma_eot),
      .pio_rd_n(pio_rd_n), .pio_wr_n(pio_wr_n), .dma_rd_n(dma_rd_n), .dma_wr_n(dma_wr_n),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .buf_space(buf_space),
      .buf_wr_valid(buf_wr_valid), .buf_wr_data(buf_wr_data), .buf_avail(buf_avail),
      .buf_rd_data(buf_rd_data), .buf_rd_pop(buf_rd_pop), .xfer_done(xfer_done)
   );

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic logic [15:0] ctrl(input bit en, input bit din, input bit rl,
                                        input bit al, input bit el, input bit sep);
      return {10'd0, sep, el, al, rl, din, en};
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // which: 0 pio_wr, 1 pio_rd, 2 dma_wr, 3 dma_rd
   task automatic word(input int which, input logic [15:0] d, input bit exp_mv,
                       input bit exp_done, input string rq);
      @(negedge clk);
      host_wdata = d;
      case (which)
         0: pio_wr_n = 1'b0;
         1: pio_rd_n = 1'b0;
         2: dma_wr_n = 1'b0;
         default: dma_rd_n = 1'b0;
      endcase
      @(negedge clk);
      pio_wr_n = 1'b1; pio_rd_n = 1'b1; dma_wr_n = 1'b1; dma_rd_n = 1'b1;
      #0.5;
      if (which % 2 == 0) begin
         chk(buf_wr_valid == exp_mv, rq, "push", buf_wr_valid, exp_mv);
         chk(buf_rd_pop == 1'b0, rq, "pop on write", buf_rd_pop, 0);
         if (exp_mv) chk(buf_wr_data == d, rq, "push data", buf_wr_data, d);
      end else begin
         chk(buf_rd_pop == exp_mv, rq, "pop", buf_rd_pop, exp_mv);
         chk(buf_wr_valid == 1'b0, rq, "push on read", buf_wr_valid, 0);
      end
      tick();
      chk(xfer_done == exp_done, rq, "done", xfer_done, exp_done);
   endtask

   task automatic t_reset();
      chk(dma_req == 1'b0, "R1", "req", dma_req, 0);
      chk(xfer_done == 1'b0, "R1", "done", xfer_done, 0);
      chk(buf_wr_valid == 1'b0 && buf_rd_pop == 1'b0, "R1", "buffer strobes",
          {buf_wr_valid, buf_rd_pop}, 0);
   endtask

   task automatic t_request();
      wr_reg(2'd1, 16'd3);
      wr_reg(2'd0, ctrl(1, 0, 0, 0, 0, 0));
      tick();
      chk(dma_req == 1'b0, "R2", "req without space", dma_req, 0);
      @(negedge clk); buf_space = 1'b1;
      tick();
      chk(dma_req == 1'b1, "R2", "req with space", dma_req, 1);
      @(negedge clk); buf_space = 1'b0;
      tick();
      chk(dma_req == 1'b0, "R2", "req withdrawn", dma_req, 0);
      @(negedge clk); buf_space = 1'b1;
      tick();
      chk(dma_req == 1'b1, "R2", "req back", dma_req, 1);
   endtask

   task automatic t_count_repeat();
      dma_ack = 1'b1;
      word(0, 16'hA001, 1, 0, "R3");
      dma_ack = 1'b0;
      word(0, 16'hBAD0, 0, 0, "R4");
      dma_ack = 1'b1;
      word(0, 16'hA002, 1, 0, "R3");
      word(0, 16'hA003, 1, 1, "R5");
      chk(dma_req == 1'b0, "R5", "req at terminal count", dma_req, 0);
      tick();
      chk(dma_req == 1'b1, "R6", "req re-armed", dma_req, 1);
      chk(xfer_done == 1'b0, "R6", "done single pulse", xfer_done, 0);
      word(0, 16'h0011, 1, 0, "R6");
      word(0, 16'h0022, 1, 0, "R6");
      word(0, 16'h0033, 1, 1, "R6");
   endtask

   task automatic t_eot();
      wr_reg(2'd1, 16'd3);
      word(0, 16'h5501, 1, 0, "R7");
      @(negedge clk); dma_eot = 1'b1;
      tick();
      chk(xfer_done == 1'b1, "R7", "done on eot", xfer_done, 1);
      tick();
      chk(xfer_done == 1'b0, "R7", "eot held no repeat", xfer_done, 0);
      @(negedge clk); dma_eot = 1'b0;
      word(0, 16'h5502, 1, 0, "R7");
      word(0, 16'h5503, 1, 0, "R7");
      word(0, 16'h5504, 1, 1, "R7");
   endtask

   task automatic t_polarity();
      wr_reg(2'd0, ctrl(0, 0, 1, 1, 1, 0));
      dma_ack = 1'b1; dma_eot = 1'b1;
      tick();
      chk(dma_req == 1'b1, "R8", "idle req high", dma_req, 1);
      wr_reg(2'd1, 16'd4);
      wr_reg(2'd0, ctrl(1, 0, 1, 1, 1, 0));
      tick();
      chk(dma_req == 1'b0, "R8", "active-low req", dma_req, 0);
      word(0, 16'h0BAD, 0, 0, "R8");
      dma_ack = 1'b0;
      word(0, 16'h1234, 1, 0, "R8");
      @(negedge clk); dma_eot = 1'b0;
      tick();
      chk(xfer_done == 1'b1, "R8", "active-low eot", xfer_done, 1);
      @(negedge clk); dma_eot = 1'b1;
      wr_reg(2'd0, ctrl(0, 0, 0, 0, 0, 0));
      dma_ack = 1'b0; dma_eot = 1'b0;
      tick();
   endtask

   task automatic t_in_dir();
      buf_avail = 1'b0; buf_space = 1'b1;
      wr_reg(2'd1, 16'd2);
      wr_reg(2'd0, ctrl(1, 1, 0, 0, 0, 0));
      tick();
      chk(dma_req == 1'b0, "R2", "in mode ignores space", dma_req, 0);
      @(negedge clk); buf_avail = 1'b1; buf_rd_data = 16'hC0DE;
      tick();
      chk(dma_req == 1'b1, "R2", "in mode req on data", dma_req, 1);
      chk(host_rdata == 16'hC0DE, "R3", "read path", host_rdata, 16'hC0DE);
      dma_ack = 1'b1;
      word(1, 16'h0, 1, 0, "R3");
      word(0, 16'h0, 0, 0, "R3");
      word(1, 16'h0, 1, 1, "R5");
      dma_ack = 1'b0;
      wr_reg(2'd0, ctrl(0, 0, 0, 0, 0, 0));
      buf_avail = 1'b0;
   endtask

   task automatic t_ports();
      wr_reg(2'd1, 16'd5);
      wr_reg(2'd0, ctrl(1, 0, 0, 0, 0, 1));
      dma_ack = 1'b1;
      word(0, 16'h7001, 0, 0, "R9");
      word(2, 16'h7002, 1, 0, "R9");
      wr_reg(2'd0, ctrl(1, 0, 0, 0, 0, 0));
      word(2, 16'h7003, 0, 0, "R9");
      word(0, 16'h7004, 1, 0, "R9");
   endtask

   task automatic t_zero();
      wr_reg(2'd1, 16'd0);
      word(0, 16'h0F0F, 1, 1, "R5");
   endtask

   task automatic t_disabled();
      wr_reg(2'd0, ctrl(0, 0, 0, 0, 0, 0));
      buf_space = 1'b1; dma_ack = 1'b1;
      tick();
      chk(dma_req == 1'b0, "R10", "req while disabled", dma_req, 0);
      word(0, 16'hDEAD, 0, 0, "R10");
      @(negedge clk); dma_eot = 1'b1;
      tick();
      chk(xfer_done == 1'b0, "R10", "eot while disabled", xfer_done, 0);
      @(negedge clk); dma_eot = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_request();
      t_count_repeat();
      t_eot();
      t_polarity();
      t_in_dir();
      t_ports();
      t_zero();
      t_disabled();
      repeat (3) tick();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule